// File: doc/BRIEF.md
# ATA Programmed-I/O Cycle Sequencer

This block performs one host-side ATA register access at a time. A request gives a direction, a 3-bit register address, a choice between the command block and the control block, and a 16-bit word to write. The block then drives the address lines, one active-low chip select, one active-low read or write strobe and the data-bus output enable. A read returns the word the device placed on the bus, together with a one-clock completion pulse.

Each access runs through four phases in order: address setup, strobe active, write hold (writes only) and recovery. Each phase has its own programmable clock count. A phase lasts its count plus one clocks, so a count of zero gives a one-clock phase. The device's IORDY line passes through a synchronizer and can stretch the strobe-active phase for as long as it stays low. While an access is in progress the block shows busy and ignores any new request.

Top module: `ata_pio_sequencer`

## Requirements
- R1: After reset both strobes and both chip selects are high, the output enable is low, and busy and done are low.
- R2: After a request is accepted, the setup phase lasts `t_setup_i`+1 clocks. During it the selected chip select is low, `da_o` shows the request address, and both strobes are high. A count of 0 gives exactly one clock.
- R3: With IORDY high, the strobe stays low for exactly `t_active_i`+1 clocks.
- R4: While the synchronized IORDY is low, the strobe does not release. When IORDY rises after the count has run out, the strobe releases after exactly SYNC_STAGES+1 rising clock edges. A low pulse on IORDY that ends before the count runs out has no effect on the strobe width.
- R5: On a read, `rdata_o` loads the `dd_i` value sampled on the clock edge at which `dior_n_o` returns high, and it keeps that value until the next read. `done_o` is high for exactly one clock, in the first clock after busy falls.
- R6: On a write, `dd_oe_o` is high from the first setup clock through the last hold clock, and `dd_o` equals the request data throughout. After the strobe rises, the selects and address stay asserted for `t_hold_i`+1 clocks. A read has no hold phase and never raises `dd_oe_o`.
- R7: The recovery phase lasts `t_recover_i`+1 clocks, with both selects high and busy still high. Busy is high from the clock after acceptance until recovery ends.
- R8: When `req_ctrl_blk_i` is 1, `cs1_n_o` is the one driven low (control block); when it is 0, `cs0_n_o` is the one driven low (command block). The two are never low together, and a strobe is low only while a select is low.
- R9: A request presented while busy is high is ignored. It changes neither the address of the access in progress nor starts a further access.
- R10: A read pulses only `dior_n_o` and a write pulses only `diow_n_o`. The two are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an access (taken only while idle) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_ctrl_blk_i | input | 1 | 1 = control block (cs1), 0 = command block (cs0) |
| req_addr_i | input | 3 | Device register address |
| req_wdata_i | input | 16 | Word to write |
| t_setup_i | input | CNT_W | Setup phase count |
| t_active_i | input | CNT_W | Strobe-active phase count |
| t_hold_i | input | CNT_W | Write hold phase count |
| t_recover_i | input | CNT_W | Recovery phase count |
| iordy_i | input | 1 | Device ready, asynchronous |
| dd_i | input | 16 | Data bus from the device |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Word captured by the last read |
| da_o | output | 3 | Device address lines |
| cs0_n_o | output | 1 | Command-block select, active low |
| cs1_n_o | output | 1 | Control-block select, active low |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| dd_o | output | 16 | Data bus to the device |
| dd_oe_o | output | 1 | Data bus output enable |

## Verification
A wrong phase register or a wrong phase count appears at the pins within the same access. It shows as a select, strobe or enable window that is one or more clocks too long or too short, so the bench measures each window's width in clocks. A capture on the wrong edge shows in `rdata_o` at the done pulse. The bench's device changes the bus partway through the strobe so that capture at the start of the strobe and capture at its end give different words. Synchronizer depth and the IORDY qualification show as a release that is off by a clock, measured from the edge at which the bench raises IORDY. A sequencer that does not ignore requests while busy starts a second access, which the bench sees as busy rising again.

// File: rtl/ata_pio_pkg.sv
`timescale 1ns/1ps
package ata_pio_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SETUP   = 3'd1,
        PH_ACTIVE  = 3'd2,
        PH_HOLD    = 3'd3,
        PH_RECOVER = 3'd4
    } pio_phase_e;

endpackage

// File: rtl/ata_pio_sync.sv
`timescale 1ns/1ps
module ata_pio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign sync_o = async_i;
        end else begin : g_chain
            logic [STAGES-1:0] sh_d, sh_q;
            logic [STAGES:0]   ext;

            always_comb begin
                ext  = {sh_q, async_i};
                sh_d = ext[STAGES-1:0];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= sh_d;
            end

            assign sync_o = sh_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ata_pio_phase_timer.sv
`timescale 1ns/1ps
module ata_pio_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)             cnt_d = load_val_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    AST_TIMER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);  // R2
endmodule

// File: rtl/ata_pio_cycle_fsm.sv
`timescale 1ns/1ps
module ata_pio_cycle_fsm
    import ata_pio_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              req_write_i,
    input  logic              req_ctrl_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [CNT_W-1:0]  t_setup_i,
    input  logic [CNT_W-1:0]  t_active_i,
    input  logic [CNT_W-1:0]  t_hold_i,
    input  logic [CNT_W-1:0]  t_recover_i,
    input  logic              iordy_s_i,
    input  logic [DATA_W-1:0] dd_i,
    input  logic              tmr_zero_i,
    output logic              tmr_load_o,
    output logic [CNT_W-1:0]  tmr_val_o,
    output pio_phase_e        phase_o,
    output logic              write_o,
    output logic              ctrl_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o
);
    typedef struct packed {
        pio_phase_e        phase;
        logic              write;
        logic              ctrl;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } fsm_state_t;

    fsm_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        tmr_load_o = 1'b0;
        tmr_val_o  = t_setup_i;
        case (s_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    s_d.phase  = PH_SETUP;
                    s_d.write  = req_write_i;
                    s_d.ctrl   = req_ctrl_i;
                    s_d.addr   = req_addr_i;
                    s_d.wdata  = req_wdata_i;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = t_setup_i;
                end
            end
            PH_SETUP: begin
                if (tmr_zero_i) begin
                    s_d.phase  = PH_ACTIVE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = t_active_i;
                end
            end
            PH_ACTIVE: begin
                if (tmr_zero_i && iordy_s_i) begin
                    tmr_load_o = 1'b1;
                    if (s_q.write) begin
                        s_d.phase = PH_HOLD;
                        tmr_val_o = t_hold_i;
                    end else begin
                        s_d.rdata = dd_i;
                        s_d.phase = PH_RECOVER;
                        tmr_val_o = t_recover_i;
                    end
                end
            end
            PH_HOLD: begin
                if (tmr_zero_i) begin
                    s_d.phase  = PH_RECOVER;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = t_recover_i;
                end
            end
            PH_RECOVER: begin
                if (tmr_zero_i) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;
    assign write_o = s_q.write;
    assign ctrl_o  = s_q.ctrl;
    assign addr_o  = s_q.addr;
    assign wdata_o = s_q.wdata;
    assign rdata_o = s_q.rdata;
    assign done_o  = s_q.done;

    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE && s_q.phase != PH_SETUP) |=> (s_q.phase != PH_SETUP));  // R9
    AST_STROBE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_ACTIVE && !tmr_zero_i) |=> (s_q.phase == PH_ACTIVE));  // R3
    AST_IORDY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_ACTIVE && !iordy_s_i) |=> (s_q.phase == PH_ACTIVE));  // R4
    AST_RDATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_ACTIVE) |=> $stable(s_q.rdata));  // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);  // R5
endmodule

// File: rtl/ata_pio_pad_drive.sv
`timescale 1ns/1ps
module ata_pio_pad_drive
    import ata_pio_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  pio_phase_e        phase_i,
    input  logic              write_i,
    input  logic              ctrl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] da_o,
    output logic              cs0_n_o,
    output logic              cs1_n_o,
    output logic              dior_n_o,
    output logic              diow_n_o,
    output logic [DATA_W-1:0] dd_o,
    output logic              dd_oe_o
);
    logic selected;
    logic strobing;

    always_comb begin
        selected = (phase_i == PH_SETUP) || (phase_i == PH_ACTIVE) || (phase_i == PH_HOLD);
        strobing = (phase_i == PH_ACTIVE);
        busy_o   = (phase_i != PH_IDLE);
        da_o     = addr_i;
        cs0_n_o  = !(selected && !ctrl_i);
        cs1_n_o  = !(selected &&  ctrl_i);
        dior_n_o = !(strobing && !write_i);
        diow_n_o = !(strobing &&  write_i);
        dd_o     = wdata_i;
        dd_oe_o  = selected && write_i;
    end
endmodule

// File: rtl/ata_pio_sequencer.sv
`timescale 1ns/1ps
module ata_pio_sequencer
    import ata_pio_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             req_write_i,
    input  logic             req_ctrl_blk_i,
    input  logic [2:0]       req_addr_i,
    input  logic [15:0]      req_wdata_i,
    input  logic [CNT_W-1:0] t_setup_i,
    input  logic [CNT_W-1:0] t_active_i,
    input  logic [CNT_W-1:0] t_hold_i,
    input  logic [CNT_W-1:0] t_recover_i,
    input  logic             iordy_i,
    input  logic [15:0]      dd_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [15:0]      rdata_o,
    output logic [2:0]       da_o,
    output logic             cs0_n_o,
    output logic             cs1_n_o,
    output logic             dior_n_o,
    output logic             diow_n_o,
    output logic [15:0]      dd_o,
    output logic             dd_oe_o
);
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;

    logic              iordy_s;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    pio_phase_e        phase;
    logic              cur_write;
    logic              cur_ctrl;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    ata_pio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(iordy_i), .sync_o(iordy_s)
    );

    ata_pio_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
    );

    ata_pio_cycle_fsm #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_i(req_i), .req_write_i(req_write_i), .req_ctrl_i(req_ctrl_blk_i),
        .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .t_setup_i(t_setup_i), .t_active_i(t_active_i),
        .t_hold_i(t_hold_i), .t_recover_i(t_recover_i),
        .iordy_s_i(iordy_s), .dd_i(dd_i), .tmr_zero_i(tmr_zero),
        .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
        .phase_o(phase), .write_o(cur_write), .ctrl_o(cur_ctrl),
        .addr_o(cur_addr), .wdata_o(cur_wdata), .rdata_o(rdata_o), .done_o(done_o)
    );

    ata_pio_pad_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pads (
        .phase_i(phase), .write_i(cur_write), .ctrl_i(cur_ctrl),
        .addr_i(cur_addr), .wdata_i(cur_wdata),
        .busy_o(busy_o), .da_o(da_o), .cs0_n_o(cs0_n_o), .cs1_n_o(cs1_n_o),
        .dior_n_o(dior_n_o), .diow_n_o(diow_n_o), .dd_o(dd_o), .dd_oe_o(dd_oe_o)
    );

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs0_n_o || cs1_n_o));  // R8
    AST_STROBE_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n_o || !diow_n_o) |-> (!cs0_n_o || !cs1_n_o));  // R8
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (dior_n_o || diow_n_o));  // R10
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !dior_n_o |-> !dd_oe_o);  // R6
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));  // R7
endmodule

// File: tb/ata_pio_sequencer_tb.sv
`timescale 1ns/1ps
module ata_pio_sequencer_tb_top;
    localparam int CNT_W = 8;
    localparam int SYNC  = 2;
    localparam logic [15:0] EARLY_WORD = 16'h0BAD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_write = 1'b0, req_ctrl = 1'b0;
    logic [2:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [CNT_W-1:0] t_setup = 8'd6, t_active = 8'd28, t_hold = 8'd2, t_recover = 8'd23;
    logic iordy = 1'b1;
    logic [15:0] dd_in;
    logic [15:0] dev_word = '0;
    int strobe_age = 0;

    logic busy, done, cs0_n, cs1_n, dior_n, diow_n, dd_oe;
    logic [15:0] rdata, dd_out;
    logic [2:0] da;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ata_pio_sequencer #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_write_i(req_write),
        .req_ctrl_blk_i(req_ctrl), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .t_setup_i(t_setup), .t_active_i(t_active), .t_hold_i(t_hold), .t_recover_i(t_recover),
        .iordy_i(iordy), .dd_i(dd_in), .busy_o(busy), .done_o(done), .rdata_o(rdata),
        .da_o(da), .cs0_n_o(cs0_n), .cs1_n_o(cs1_n), .dior_n_o(dior_n), .diow_n_o(diow_n),
        .dd_o(dd_out), .dd_oe_o(dd_oe)
    );

    // Device model: the bus shows a junk word in the first strobe clock, the real word after.
    always @(posedge clk) strobe_age <= dior_n ? 0 : strobe_age + 1;
    assign dd_in = dior_n ? 16'hFFFF : ((strobe_age >= 1) ? dev_word : EARLY_WORD);

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", rq, what, act, act, exp, exp);
        end
    endtask

    task automatic t_reset_state();
        chk("R1", "cs0_n idle", int'(cs0_n), 1);
        chk("R1", "cs1_n idle", int'(cs1_n), 1);
        chk("R1", "dior_n idle", int'(dior_n), 1);
        chk("R1", "diow_n idle", int'(diow_n), 1);
        chk("R1", "dd_oe idle", int'(dd_oe), 0);
        chk("R1", "busy idle", int'(busy), 0);
        chk("R1", "done idle", int'(done), 0);
    endtask

    // One access, measured at the pins. release_at: active clock at which IORDY is raised (0 = high).
    task automatic run_xfer(input string name, input bit wr, input bit ctl, input logic [2:0] a,
                            input logic [15:0] wd, input logic [15:0] rv,
                            input int t1, input int t2, input int t4, input int te,
                            input int release_at, input int inject_at, input int exp_active);
        int n_setup = 0, n_active = 0, n_hold = 0, n_rec = 0, n_oe = 0;
        int bad_sel = 0, bad_da = 0, bad_dd = 0, bad_strobe = 0;
        int k = 0;
        bit seen_strobe = 0;
        logic [15:0] exp_rd;
        t_setup = t1[CNT_W-1:0]; t_active = t2[CNT_W-1:0];
        t_hold = t4[CNT_W-1:0]; t_recover = te[CNT_W-1:0];
        dev_word = rv;
        iordy = (release_at == 0);
        @(negedge clk);
        req = 1'b1; req_write = wr; req_ctrl = ctl; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        forever begin
            if (!busy || k > 2000) break;
            k++;
            if (!dior_n || !diow_n) begin
                n_active++;
                seen_strobe = 1;
                if (wr ? (diow_n || !dior_n) : (dior_n || !diow_n)) bad_strobe++;
                if (release_at != 0 && n_active == release_at) iordy = 1'b1;
            end
            if (!cs0_n || !cs1_n) begin
                if (ctl ? (cs1_n || !cs0_n) : (cs0_n || !cs1_n)) bad_sel++;
                if (da !== a) bad_da++;
                if (dior_n && diow_n) begin
                    if (seen_strobe) n_hold++; else n_setup++;
                end
            end else begin
                n_rec++;
                if (!dior_n || !diow_n) bad_sel++;
            end
            if (dd_oe) begin
                n_oe++;
                if (dd_out !== wd) bad_dd++;
            end
            if (req) req = 1'b0;
            if (k == inject_at) begin
                req = 1'b1; req_write = ~wr; req_ctrl = ~ctl; req_addr = a ^ 3'b111;
            end
            @(negedge clk);
        end
        req = 1'b0;
        iordy = 1'b1;
        chk("R2", {name, " setup clocks"}, n_setup, t1 + 1);
        if (release_at > 1) chk("R4", {name, " stretched strobe clocks"}, n_active, exp_active);
        else                chk("R3", {name, " strobe clocks"}, n_active, exp_active);
        chk("R6", {name, " hold clocks"}, n_hold, wr ? t4 + 1 : 0);
        chk("R7", {name, " recovery clocks"}, n_rec, te + 1);
        chk("R6", {name, " output-enable clocks"}, n_oe, wr ? (t1 + 1 + exp_active + t4 + 1) : 0);
        chk("R6", {name, " driven data mismatches"}, bad_dd, 0);
        chk("R8", {name, " select mismatches"}, bad_sel, 0);
        chk("R2", {name, " address mismatches"}, bad_da, 0);
        chk("R10", {name, " wrong strobe clocks"}, bad_strobe, 0);
        chk("R5", {name, " done after busy falls"}, int'(done), 1);
        if (!wr) begin
            exp_rd = (exp_active == 1) ? EARLY_WORD : rv;
            chk("R5", {name, " read word"}, int'(rdata), int'(exp_rd));
        end
        @(negedge clk);
        chk("R5", {name, " done is one clock"}, int'(done), 0);
    endtask

    task automatic t_read_default();
        run_xfer("read cmd", 1'b0, 1'b0, 3'd7, 16'h0000, 16'hA5C3, 6, 28, 2, 23, 0, -1, 29);
    endtask

    task automatic t_write_default();
        run_xfer("write ctrl", 1'b1, 1'b1, 3'd6, 16'h3C5A, 16'h0000, 6, 28, 2, 23, 0, -1, 29);
    endtask

    task automatic t_zero_counts();
        run_xfer("write zero", 1'b1, 1'b0, 3'd1, 16'h8001, 16'h0000, 0, 0, 0, 0, 0, -1, 1);
        run_xfer("read zero", 1'b0, 1'b1, 3'd2, 16'h0000, 16'h1234, 0, 0, 0, 0, 0, -1, 1);
    endtask

    task automatic t_iordy_stretch();
        // raised at active clock 8 with count 3: release after SYNC+1 edges
        run_xfer("read stretch", 1'b0, 1'b0, 3'd3, 16'h0000, 16'h7E81, 2, 3, 1, 4, 8, -1, 8 + SYNC);
        run_xfer("write stretch", 1'b1, 1'b1, 3'd5, 16'hBEEF, 16'h0000, 1, 0, 3, 2, 5, -1, 5 + SYNC);
    endtask

    task automatic t_iordy_dip();
        // IORDY low at strobe start, back high well before the count runs out (R4: no effect)
        run_xfer("write dip", 1'b1, 1'b0, 3'd4, 16'h55AA, 16'h0000, 3, 12, 1, 3, 1, -1, 13);
    endtask

    task automatic t_ignore_while_busy();
        int extra = 0;
        run_xfer("read with stray request", 1'b0, 1'b0, 3'd0, 16'h0000, 16'hC0DE, 2, 5, 1, 6, 0, 3, 6);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (busy) extra++;
        end
        chk("R9", "busy after stray request", extra, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_read_default();
        t_write_default();
        t_zero_counts();
        t_iordy_stretch();
        t_iordy_dip();
        t_ignore_while_busy();
        t_reset_state();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule